// File: doc/BRIEF.md
# Parallel Bus Transmitter

This block takes bytes from an upstream valid/ready source and spreads each byte over a parallel output bus. The bus is 1, 2, 4 or 8 bits wide, and the block presents one slice per clock. A configuration bit picks whether a byte is unpacked starting at its low end or at its high end. When no frame is in progress, the bus carries a programmable idle value.

A frame starts when the start level is raised. It ends in one of two ways, chosen at start time: after a programmed number of bits, or after the upstream byte flagged as last. The top data line can be taken over as a transmit strobe. Separately, the line can gate the output clock enable.

Three event bits record three conditions: a starved input (bit 0), an unused receive slot (bit 1) and end of frame (bit 2). Each bit is write-one-to-clear. Their enabled OR drives an interrupt line. A ready output reports that the unit can take a new start.

Top module: `pbus_tx`

## Requirements
- R1: `cfg_width_sel` values 0, 1, 2 and 3 select bus widths of 1, 2, 4 and 8 lines. While bytes keep arriving, one slice appears on `bus_data` every clock with no gap between bytes. A byte accepted on clock edge E shows its first slice after edge E+1.
- R2: With `cfg_msb_first` = 0, the first slice of a byte is bits [W-1:0], and later slices move upward. With `cfg_msb_first` = 1, the first slice is bits [7:8-W], and later slices move downward. Each slice sits on lines [W-1:0], and the unused lines are 0.
- R3: In length mode (`cfg_end_by_marker` = 0), the frame ends once `cfg_bit_len` bits have been sent. `cfg_bit_len` is a multiple of 8, at most 0x7FFFF. No further byte is accepted after the last one needed, and event bit 2 is set.
- R4: In marker mode (`cfg_end_by_marker` = 1), `cfg_bit_len` is ignored. The frame ends after the last slice of the byte accepted with `s_last` high, and event bit 2 is set.
- R5: When no frame is running, `bus_data` carries `cfg_idle_value`. It returns to that value on the clock after the final slice.
- R6: With `cfg_strobe_en` = 1, line 7 is high exactly in the cycles that carry a new slice, and low in all other cycles, including idle.
- R7: `bus_clk_en` equals line 7 of `bus_data` when `cfg_gate_en` = 1, and is constantly 1 when `cfg_gate_en` = 0.
- R8: If the unit wants a byte in mid-frame while none is offered, event bit 0 is set. The data lines keep the last slice until the next byte arrives.
- R9: Clearing `cfg_start` during a frame stops byte acceptance at once. The byte already held finishes all its slices, and the bus then returns to idle without setting event bit 2.
- R10: `tx_ready` is high only in idle. After a frame ends, it stays low until `cfg_start` has been cleared.
- R11: `evt_pending` bits clear when a 1 is written on the matching `evt_clear` bit; a set in the same cycle wins. `irq` is the OR of pending bits masked by `evt_enable`. Bit 1 is never set by this unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus slice per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Level that starts and keeps a frame running |
| cfg_width_sel | input | 2 | Bus width code (0:1, 1:2, 2:4, 3:8 lines) |
| cfg_msb_first | input | 1 | Unpack each byte from its high end |
| cfg_end_by_marker | input | 1 | End frame on `s_last` instead of bit count |
| cfg_bit_len | input | 19 | Frame length in bits for length mode |
| cfg_strobe_en | input | 1 | Line 7 carries the transmit strobe |
| cfg_gate_en | input | 1 | Clock enable follows line 7 |
| cfg_idle_value | input | 8 | Value driven while idle |
| s_valid | input | 1 | Upstream byte offered |
| s_data | input | 8 | Upstream byte |
| s_last | input | 1 | Upstream byte closes the frame |
| s_ready | output | 1 | Unit takes the offered byte this cycle |
| bus_data | output | 8 | Parallel output lines |
| bus_clk_en | output | 1 | Enable for the output clock |
| tx_ready | output | 1 | Unit is idle and accepts a start |
| evt_enable | input | 3 | Interrupt enable per event bit |
| evt_clear | input | 3 | Write-one-to-clear per event bit |
| evt_pending | output | 3 | Latched events (0 starved, 1 unused, 2 end of frame) |
| irq | output | 1 | OR of enabled pending events |

## Verification
The bench watches the seam between bytes at every width. If the engine left a gap cycle there, or fetched the next byte one slice too early, slices would drop, repeat or shift in time, and the scoreboard would see a mismatch.

Marker mode is run with a length that would end the frame after the first byte. An engine that consulted the length in the wrong mode would stop half way.

A deliberate mid-frame stall checks three things. The data lines must hold their value, the strobe must fall and the starved event must fire. A design that kept the strobe up, or let the lines drift, fails there.

A stop issued right after a byte is accepted checks that the byte still finishes all its slices. It also checks that no end-of-frame event is reported.

// File: rtl/pbus_tx_pkg.sv
package pbus_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_RUN  = 2'd1,
        TX_HOLD = 2'd2
    } tx_state_e;

    // event bit positions; receive slot kept for layout compatibility
    localparam int EV_STARVED = 0;
    localparam int EV_RX_SLOT = 1;
    localparam int EV_EOF     = 2;

endpackage

// File: rtl/pbus_tx_slicer.sv
module pbus_tx_slicer #(
    parameter int BUS_W = 8,
    parameter int SEL_W = 2,
    parameter int IDX_W = 3
) (
    input  logic [BUS_W-1:0] word_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             msb_first_i,
    output logic [BUS_W-1:0] slice_o
);

    int               lanes;
    int               base;
    logic [BUS_W-1:0] shifted;

    always_comb begin
        lanes = 1 << sel_i;
        if (msb_first_i) begin
            base = BUS_W - (int'(idx_i) + 1) * lanes;
        end else begin
            base = int'(idx_i) * lanes;
        end
        shifted = word_i >> base;
    end

    for (genvar g = 0; g < BUS_W; g++) begin : g_lane
        assign slice_o[g] = (g < lanes) && shifted[g];
    end

endmodule

// File: rtl/pbus_tx_events.sv
module pbus_tx_events #(
    parameter int EVT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] set_i,
    input  logic [EVT_N-1:0] clr_i,
    input  logic [EVT_N-1:0] en_i,
    output logic [EVT_N-1:0] pend_o,
    output logic             irq_o
);

    logic [EVT_N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & en_i);

endmodule

// File: rtl/pbus_tx.sv
module pbus_tx
    import pbus_tx_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int LEN_W = 19,
    parameter int EVT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic [1:0]       cfg_width_sel,
    input  logic             cfg_msb_first,
    input  logic             cfg_end_by_marker,
    input  logic [LEN_W-1:0] cfg_bit_len,
    input  logic             cfg_strobe_en,
    input  logic             cfg_gate_en,
    input  logic [BUS_W-1:0] cfg_idle_value,
    input  logic             s_valid,
    input  logic [BUS_W-1:0] s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_clk_en,
    output logic             tx_ready,
    input  logic [EVT_N-1:0] evt_enable,
    input  logic [EVT_N-1:0] evt_clear,
    output logic [EVT_N-1:0] evt_pending,
    output logic             irq
);

    localparam int IDX_W = $clog2(BUS_W);
    localparam int SEL_W = 2;
    localparam int TOP   = BUS_W - 1;

    typedef struct packed {
        tx_state_e        state;
        logic [SEL_W-1:0] wsel;
        logic             msb;
        logic             marker;
        logic [BUS_W-1:0] word;
        logic             have;
        logic             last;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] rem;
        logic [BUS_W-1:0] bus;
    } regs_t;

    regs_t r_d, r_q;

    logic [BUS_W-1:0] slice;
    logic [IDX_W-1:0] last_idx;
    logic [LEN_W-1:0] slice_bits;
    logic             emit;
    logic             last_slice;
    logic             final_slice;
    logic             frame_end;
    logic             want_byte;
    logic [EVT_N-1:0] ev_set;

    pbus_tx_slicer #(
        .BUS_W (BUS_W),
        .SEL_W (SEL_W),
        .IDX_W (IDX_W)
    ) slicer_i (
        .word_i      (r_q.word),
        .sel_i       (r_q.wsel),
        .idx_i       (r_q.idx),
        .msb_first_i (r_q.msb),
        .slice_o     (slice)
    );

    always_comb begin
        r_d         = r_q;
        ev_set      = '0;
        last_idx    = IDX_W'((BUS_W >> r_q.wsel) - 1);
        slice_bits  = LEN_W'(1 << r_q.wsel);
        emit        = (r_q.state == TX_RUN) && r_q.have;
        last_slice  = r_q.have && (r_q.idx == last_idx);
        final_slice = last_slice &&
                      (r_q.marker ? r_q.last : (r_q.rem == slice_bits));
        frame_end   = (r_q.state == TX_RUN) &&
                      (final_slice || (!r_q.have && !r_q.marker && r_q.rem == '0));
        want_byte   = (r_q.state == TX_RUN) && cfg_start && !frame_end &&
                      (!r_q.have || last_slice);

        case (r_q.state)
            TX_IDLE: begin
                if (cfg_start) begin
                    r_d.state  = TX_RUN;
                    r_d.wsel   = cfg_width_sel;
                    r_d.msb    = cfg_msb_first;
                    r_d.marker = cfg_end_by_marker;
                    r_d.rem    = cfg_bit_len;
                    r_d.have   = 1'b0;
                    r_d.idx    = '0;
                end
            end
            TX_RUN: begin
                if (emit) begin
                    r_d.bus = slice;
                    r_d.idx = r_q.idx + IDX_W'(1);
                    if (!r_q.marker) begin
                        r_d.rem = r_q.rem - slice_bits;
                    end
                end
                if (last_slice) begin
                    r_d.have = 1'b0;
                    r_d.idx  = '0;
                end
                if (want_byte && s_valid) begin
                    r_d.word = s_data;
                    r_d.last = s_last;
                    r_d.have = 1'b1;
                    r_d.idx  = '0;
                end
                if (want_byte && !s_valid && !r_q.have) begin
                    ev_set[EV_STARVED] = 1'b1;
                end
                if (frame_end) begin
                    r_d.state        = TX_HOLD;
                    r_d.have         = 1'b0;
                    ev_set[EV_EOF]   = 1'b1;
                end else if (!cfg_start && (!r_q.have || last_slice)) begin
                    r_d.state = TX_IDLE;
                    r_d.have  = 1'b0;
                end
            end
            TX_HOLD: begin
                if (!cfg_start) begin
                    r_d.state = TX_IDLE;
                end
            end
            default: r_d.state = TX_IDLE;
        endcase

        if (r_q.state != TX_RUN) begin
            r_d.bus = cfg_idle_value;
        end
        if (cfg_strobe_en) begin
            r_d.bus[TOP] = emit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: TX_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    pbus_tx_events #(
        .EVT_N (EVT_N)
    ) events_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (evt_clear),
        .en_i   (evt_enable),
        .pend_o (evt_pending),
        .irq_o  (irq)
    );

    assign s_ready    = want_byte;
    assign bus_data   = r_q.bus;
    assign bus_clk_en = !cfg_gate_en || r_q.bus[TOP];
    assign tx_ready   = (r_q.state == TX_IDLE);

endmodule

// File: rtl/pbus_tx_chk.sv
module pbus_tx_chk #(
    parameter int BUS_W = 8,
    parameter int EVT_N = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_start,
    input logic             cfg_strobe_en,
    input logic [BUS_W-1:0] cfg_idle_value,
    input logic             s_ready,
    input logic [BUS_W-1:0] bus_data,
    input logic             tx_ready,
    input logic [EVT_N-1:0] evt_pending
);

    // R9: no byte is taken once start has been withdrawn
    a_r9_accept_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> cfg_start);

    // R10: the unit never reports ready while it is taking bytes
    a_r10_busy_when_accepting: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !tx_ready);

    // R5: idle cycles drive the programmed value one clock later
    a_r5_idle_value: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !cfg_strobe_en) |=> (bus_data == $past(cfg_idle_value)));

    // R6: strobe line stays low while idle
    a_r6_strobe_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && cfg_strobe_en) |=> !bus_data[BUS_W-1]);

    // R3: an end-of-frame event leaves the unit busy until start is cleared
    a_r3_eof_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_pending[EVT_N-1]) |-> !tx_ready);

endmodule

bind pbus_tx pbus_tx_chk #(
    .BUS_W (BUS_W),
    .EVT_N (EVT_N)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start      (cfg_start),
    .cfg_strobe_en  (cfg_strobe_en),
    .cfg_idle_value (cfg_idle_value),
    .s_ready        (s_ready),
    .bus_data       (bus_data),
    .tx_ready       (tx_ready),
    .evt_pending    (evt_pending)
);

// File: tb/pbus_tx_tb_top.sv
module pbus_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [1:0]  cfg_width_sel = 2'd3;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_end_by_marker = 1'b0;
    logic [18:0] cfg_bit_len = '0;
    logic        cfg_strobe_en = 1'b0;
    logic        cfg_gate_en = 1'b0;
    logic [7:0]  cfg_idle_value = 8'h5A;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic [7:0]  bus_data;
    logic        bus_clk_en;
    logic        tx_ready;
    logic [2:0]  evt_enable = '0;
    logic [2:0]  evt_clear = '0;
    logic [2:0]  evt_pending;
    logic        irq;

    always #5 clk = ~clk;

    pbus_tx dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_start         (cfg_start),
        .cfg_width_sel     (cfg_width_sel),
        .cfg_msb_first     (cfg_msb_first),
        .cfg_end_by_marker (cfg_end_by_marker),
        .cfg_bit_len       (cfg_bit_len),
        .cfg_strobe_en     (cfg_strobe_en),
        .cfg_gate_en       (cfg_gate_en),
        .cfg_idle_value    (cfg_idle_value),
        .s_valid           (s_valid),
        .s_data            (s_data),
        .s_last            (s_last),
        .s_ready           (s_ready),
        .bus_data          (bus_data),
        .bus_clk_en        (bus_clk_en),
        .tx_ready          (tx_ready),
        .evt_enable        (evt_enable),
        .evt_clear         (evt_clear),
        .evt_pending       (evt_pending),
        .irq               (irq)
    );

    int         n_checks = 0;
    int         n_fail = 0;
    logic [7:0] exp_q[$];
    int         mon_mode = 0;
    string      mon_req = "R1";
    bit         hs_p1 = 1'b0;
    bit         hs_p2 = 1'b0;
    logic [7:0] mon_e;
    int         sb_sel = 3;
    bit         sb_msb = 1'b0;
    bit         sb_strobe = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_mode == 1) begin
                if (bus_data[7]) begin
                    if (exp_q.size() == 0) begin
                        chk(mon_req, "extra strobed slice", 32'd1, 32'd0);
                    end else begin
                        mon_e = exp_q.pop_front();
                        chk(mon_req, "strobed slice", 32'(bus_data), 32'(mon_e));
                    end
                    if (cfg_gate_en) chk("R7", "clock enable on strobe", 32'(bus_clk_en), 32'd1);
                end
            end else if (mon_mode == 2) begin
                if (hs_p2) begin
                    if (exp_q.size() == 0) begin
                        chk(mon_req, "missing expected byte", 32'd1, 32'd0);
                    end else begin
                        mon_e = exp_q.pop_front();
                        chk(mon_req, "byte lane value", 32'(bus_data), 32'(mon_e));
                    end
                end
                hs_p2 = hs_p1;
                hs_p1 = s_valid && s_ready;
            end else begin
                hs_p1 = 1'b0;
                hs_p2 = 1'b0;
            end
        end
    end

    task automatic push_slices(input logic [7:0] d);
        int w;
        w = 1 << sb_sel;
        for (int k = 0; k < 8 / w; k++) begin
            int pos;
            logic [7:0] s;
            pos = sb_msb ? 8 - (k + 1) * w : k * w;
            s = (d >> pos) & 8'((1 << w) - 1);
            if (sb_strobe) s[7] = 1'b1;
            exp_q.push_back(s);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input logic lst);
        bit got;
        s_valid = 1'b1;
        s_data  = d;
        s_last  = lst;
        while (1) begin
            #1;
            got = s_ready;
            @(posedge clk);
            if (got) break;
            @(negedge clk);
        end
        push_slices(d);
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic start_frame(input int sel, input bit msb, input bit marker,
                               input int len, input bit strobe);
        cfg_width_sel     = 2'(sel);
        cfg_msb_first     = msb;
        cfg_end_by_marker = marker;
        cfg_bit_len       = 19'(len);
        cfg_strobe_en     = strobe;
        sb_sel            = sel;
        sb_msb            = msb;
        sb_strobe         = strobe;
        cfg_start         = 1'b1;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_frame();
        cfg_start = 1'b0;
        wait_neg(2);
        evt_clear = 3'b111;
        @(negedge clk);
        evt_clear = 3'b000;
        wait_neg(1);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);

        // reset state
        chk("R10", "ready after reset", 32'(tx_ready), 32'd1);
        chk("R9", "no accept after reset", 32'(s_ready), 32'd0);
        chk("R11", "no events after reset", 32'(evt_pending), 32'd0);
        chk("R5", "idle value after reset", 32'(bus_data), 32'h5A);
        chk("R7", "clock enable ungated", 32'(bus_clk_en), 32'd1);

        // 8 lanes, length mode, back to back
        mon_mode = 2; mon_req = "R1";
        @(negedge clk);
        start_frame(3, 0, 0, 32, 0);
        send_byte(8'hA1, 1'b0);
        send_byte(8'hB2, 1'b0);
        send_byte(8'hC3, 1'b0);
        send_byte(8'hD4, 1'b0);
        #1;
        chk("R3", "no accept after length reached", 32'(s_ready), 32'd0);
        wait_neg(2);
        chk("R1", "all bytes emitted", 32'(exp_q.size()), 32'd0);
        chk("R3", "end of frame event", 32'(evt_pending[2]), 32'd1);
        chk("R8", "no starve in continuous stream", 32'(evt_pending[0]), 32'd0);
        chk("R11", "irq masked", 32'(irq), 32'd0);
        chk("R10", "busy while start held", 32'(tx_ready), 32'd0);
        chk("R5", "idle after frame", 32'(bus_data), 32'h5A);
        finish_frame();
        chk("R10", "ready after start cleared", 32'(tx_ready), 32'd1);
        chk("R11", "events cleared by write one", 32'(evt_pending), 32'd0);
        mon_mode = 0;

        // 4 lanes, high end first, strobe
        cfg_idle_value = 8'hC3;
        mon_mode = 1; mon_req = "R2";
        start_frame(2, 1, 0, 16, 1);
        send_byte(8'h3C, 1'b0);
        send_byte(8'hA5, 1'b0);
        wait_neg(5);
        chk("R2", "high-first slices emitted", 32'(exp_q.size()), 32'd0);
        chk("R3", "end of frame after 16 bits", 32'(evt_pending[2]), 32'd1);
        chk("R6", "strobe low in idle", 32'(bus_data), 32'h43);
        finish_frame();

        // 1 lane, marker mode, length ignored
        mon_req = "R4";
        start_frame(0, 0, 1, 8, 1);
        send_byte(8'h96, 1'b0);
        send_byte(8'h0F, 1'b1);
        wait_neg(12);
        chk("R4", "marker frame emitted fully", 32'(exp_q.size()), 32'd0);
        chk("R4", "end of frame on marker", 32'(evt_pending[2]), 32'd1);
        chk("R4", "no accept after marker", 32'(s_ready), 32'd0);
        finish_frame();

        // 2 lanes with a stall, clock gating
        evt_enable = 3'b001;
        cfg_gate_en = 1'b1;
        mon_req = "R8";
        start_frame(1, 0, 0, 24, 1);
        send_byte(8'hE1, 1'b0);
        wait_neg(7);
        chk("R8", "lines hold last slice", 32'(bus_data), 32'h03);
        chk("R8", "starved event", 32'(evt_pending[0]), 32'd1);
        chk("R11", "irq from enabled event", 32'(irq), 32'd1);
        chk("R7", "clock gated during stall", 32'(bus_clk_en), 32'd0);
        send_byte(8'h77, 1'b0);
        send_byte(8'h2D, 1'b0);
        wait_neg(8);
        chk("R8", "stream resumed fully", 32'(exp_q.size()), 32'd0);
        chk("R3", "end of frame after stall", 32'(evt_pending[2]), 32'd1);
        chk("R11", "receive slot never set", 32'(evt_pending[1]), 32'd0);
        cfg_gate_en = 1'b0;
        evt_enable = 3'b000;
        finish_frame();
        chk("R11", "irq low after clear", 32'(irq), 32'd0);

        // stop mid frame
        mon_req = "R9";
        start_frame(1, 1, 0, 64, 1);
        send_byte(8'h4B, 1'b0);
        cfg_start = 1'b0;
        wait_neg(7);
        chk("R9", "held byte finished", 32'(exp_q.size()), 32'd0);
        chk("R9", "ready after stop", 32'(tx_ready), 32'd1);
        chk("R9", "no end of frame on stop", 32'(evt_pending[2]), 32'd0);
        chk("R9", "idle after stop", 32'(bus_data), 32'h43);
        mon_mode = 0;

        // idle value and strobe/gate interplay
        cfg_idle_value = 8'hFF;
        cfg_strobe_en = 1'b1;
        cfg_gate_en = 1'b1;
        wait_neg(2);
        chk("R6", "strobe forces line 7 low in idle", 32'(bus_data), 32'h7F);
        chk("R7", "gated clock off in idle", 32'(bus_clk_en), 32'd0);
        cfg_strobe_en = 1'b0;
        wait_neg(2);
        chk("R5", "idle value all ones", 32'(bus_data), 32'hFF);
        chk("R7", "gated clock follows line 7", 32'(bus_clk_en), 32'd1);
        cfg_gate_en = 1'b0;

        chk("R1", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule